// File: doc/BRIEF.md
# Electronic Shutter Pulse Sequencer

This block times the substrate-discharge pulses that clear an image sensor's photosites and drives a level that marks the exposure window. The exposure runs over a programmable number of whole fields plus a remainder of lines. A burst of discharge pulses, one per line at the start of a chosen field, sets where the exposure begins. The readout that closes the exposure is honoured only in the last field of the cycle.

The surrounding timing logic supplies line and field strobes, the pixel position inside the current line, and a flag that marks the line holding the readout pulse. Configuration is offered through a load strobe. A busy flag tells the configuration side when a load would be refused. An accepted setting waits until the next exposure cycle begins.

Top module: `shutter_seq`

## Requirements
- R1: With the active enable at 0, `sub_req` never goes high. `exp_lvl` rises when `pix_pos` reaches RISE_POS (default 1416) on a readout line of the final field, so the exposure lasts one field.
- R2: In the burst field, each line with index 0 to H (index 0 is the line opened by `field_start`) carries one SUB pulse. `sub_req` is high for pixel positions SUB_ON up to SUB_OFF-1 (defaults 100 and 180). The burst therefore holds H+1 pulses.
- R3: With V=0, every field is a whole cycle and carries the burst when F=0. `exp_lvl` rises at position SUB_OFF on line H and falls at the readout position of the same field.
- R4: With V of 1 or more, a cycle spans V+1 fields. A readout line ends the exposure only in field index V. Readout lines in fields 0 to V-1 leave `exp_lvl` unchanged.
- R5: The burst goes to field index F of the cycle, counted from 0. When F exceeds V there is no burst, and `exp_lvl` rises at RISE_POS on the final readout line as in R1.
- R6: `exp_lvl` falls on a final-field readout line at position 1338 when `frame_mode`=0, and at 1260 when `frame_mode`=1. The other position has no effect.
- R7: While `ro_hold`=1, readout lines change nothing on `exp_lvl`.
- R8: `long_busy` is 1 from the field_start that opens fields 0 to V-1 of a cycle with V of 1 or more. It is 0 during field V and whenever V=0.
- R9: `cfg_load` is ignored while `long_busy`=1. An accepted load takes effect at the field_start that begins the next cycle, not before.
- R10: After reset, `sub_req`, `exp_lvl` and `long_busy` are 0 and the active setting is all zero (shutter disabled, V=0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_load | input | 1 | Strobe offering the cfg_* values |
| cfg_en | input | 1 | Shutter enable for the offered setting |
| cfg_vcnt | input | 10 | Extra fields V of the exposure |
| cfg_hcnt | input | 11 | Last burst line index H |
| cfg_fsel | input | 10 | Burst field index F |
| ro_hold | input | 1 | Readout suppress, level |
| frame_mode | input | 1 | Selects the 1260 fall position |
| line_start | input | 1 | Line strobe, pix_pos at 0 |
| field_start | input | 1 | Field strobe, given with line_start |
| pix_pos | input | 12 | Pixel count inside the line |
| ro_line | input | 1 | Current line holds the readout pulse |
| sub_req | output | 1 | Discharge pulse request |
| exp_lvl | output | 1 | High during exposure |
| long_busy | output | 1 | Long exposure in progress, loads refused |

## Verification
A table walks a high-speed setup over positions just inside and just outside the pulse window, over lines before, at and past the last burst line, and over the readout positions. This separates off-by-one errors in the window, in the line range and in the rise point. Directed runs with the shutter disabled and in frame mode show which readout position closes the exposure and whether the no-burst rise happens. A three-field exposure with the burst in the middle field shows whether intermediate readouts are ignored, when busy clears, and whether loads are refused. Settings with the burst field beyond V, and loads given mid-cycle, show whether a new setting is applied early.

// File: rtl/shut_pkg.sv
`timescale 1ns/1ps
package shut_pkg;
  localparam int VCW = 10;  // field count width
  localparam int HCW = 11;  // line count width, also line index width

  typedef struct packed {
    logic           en;
    logic [VCW-1:0] vcnt;
    logic [HCW-1:0] hcnt;
    logic [VCW-1:0] fsel;
  } shut_cfg_t;
endpackage

// File: rtl/shut_field_ctl.sv
`timescale 1ns/1ps
module shut_field_ctl
  import shut_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            cfg_load,
  input  shut_cfg_t       cfg_in,
  input  logic            line_start,
  input  logic            field_start,
  output shut_cfg_t       act,
  output logic [VCW-1:0]  fcnt,
  output logic [HCW-1:0]  line_idx,
  output logic            busy
);
  shut_cfg_t      pend_q, act_q, nxt_act;
  logic           pend_v;
  logic [VCW-1:0] fcnt_q, nxt_fcnt;
  logic [HCW-1:0] line_q;
  logic           busy_q, cyc_start, busy_d;

  // a new exposure cycle opens at the field after the final one
  assign cyc_start = field_start && (fcnt_q == act_q.vcnt);
  assign nxt_act   = (cyc_start && pend_v) ? pend_q : act_q;

  always_comb begin
    nxt_fcnt = fcnt_q;
    if (field_start) nxt_fcnt = cyc_start ? '0 : fcnt_q + VCW'(1);
  end

  assign busy_d = (nxt_act.vcnt != '0) && (nxt_fcnt != nxt_act.vcnt);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      pend_v <= 1'b0;
      act_q  <= '0;
      fcnt_q <= '0;
      line_q <= '0;
      busy_q <= 1'b0;
    end else begin
      if (cyc_start && pend_v) pend_v <= 1'b0;
      if (cfg_load && !busy_q) begin
        pend_q <= cfg_in;
        pend_v <= 1'b1;
      end
      act_q  <= nxt_act;
      fcnt_q <= nxt_fcnt;
      busy_q <= busy_d;
      if (field_start)
        line_q <= '0;
      else if (line_start && (line_q != '1))
        line_q <= line_q + HCW'(1);
    end
  end

  assign act      = act_q;
  assign fcnt     = fcnt_q;
  assign line_idx = line_q;
  assign busy     = busy_q;

  a_r4_fcnt_bounded: assert property (@(posedge clk) disable iff (rst)
    fcnt_q <= act_q.vcnt);
  a_r8_busy_not_final: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> (fcnt_q != act_q.vcnt));
  a_r9_load_refused: assert property (@(posedge clk) disable iff (rst)
    (busy_q && cfg_load) |=> (pend_q == $past(pend_q)));
  a_r9_act_only_at_field: assert property (@(posedge clk) disable iff (rst)
    !field_start |=> (act_q == $past(act_q)));
endmodule

// File: rtl/shut_pulse_gen.sv
`timescale 1ns/1ps
module shut_pulse_gen
  import shut_pkg::*;
#(
  parameter int PIX_W      = 12,
  parameter int SUB_ON     = 100,
  parameter int SUB_OFF    = 180,
  parameter int RISE_POS   = 1416,
  parameter int FALL_DRAFT = 1338,
  parameter int FALL_FRAME = 1260
)(
  input  logic             clk,
  input  logic             rst,
  input  shut_cfg_t        act,
  input  logic [VCW-1:0]   fcnt,
  input  logic [HCW-1:0]   line_idx,
  input  logic [PIX_W-1:0] pix_pos,
  input  logic             ro_line,
  input  logic             ro_hold,
  input  logic             frame_mode,
  output logic             sub_q,
  output logic             exp_q
);
  localparam logic [PIX_W-1:0] P_ON   = PIX_W'(SUB_ON);
  localparam logic [PIX_W-1:0] P_OFF  = PIX_W'(SUB_OFF);
  localparam logic [PIX_W-1:0] P_RISE = PIX_W'(RISE_POS);
  localparam logic [PIX_W-1:0] P_FD   = PIX_W'(FALL_DRAFT);
  localparam logic [PIX_W-1:0] P_FF   = PIX_W'(FALL_FRAME);

  logic             burst_fld, in_win, sub_d, last_fall, ro_ok, no_burst, exp_d;
  logic [PIX_W-1:0] fall_pos;

  assign burst_fld = act.en && (fcnt == act.fsel);
  assign in_win    = (pix_pos >= P_ON) && (pix_pos < P_OFF);
  assign sub_d     = burst_fld && (line_idx <= act.hcnt) && in_win;
  assign last_fall = burst_fld && (line_idx == act.hcnt) && (pix_pos == P_OFF);
  assign ro_ok     = ro_line && !ro_hold && (fcnt == act.vcnt);
  assign no_burst  = !act.en || (act.fsel > act.vcnt);
  assign fall_pos  = frame_mode ? P_FF : P_FD;

  always_comb begin
    exp_d = exp_q;
    if (last_fall)                                exp_d = 1'b1;
    else if (ro_ok && (pix_pos == fall_pos))      exp_d = 1'b0;
    else if (ro_ok && no_burst && (pix_pos == P_RISE)) exp_d = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sub_q <= 1'b0;
      exp_q <= 1'b0;
    end else begin
      sub_q <= sub_d;
      exp_q <= exp_d;
    end
  end

  a_r1_no_sub_disabled: assert property (@(posedge clk) disable iff (rst)
    !act.en |=> !sub_q);
  a_r2_sub_in_window: assert property (@(posedge clk) disable iff (rst)
    sub_q |-> (($past(pix_pos) >= P_ON) && ($past(pix_pos) < P_OFF)));
  a_r7_fall_needs_readout: assert property (@(posedge clk) disable iff (rst)
    $fell(exp_q) |-> $past(ro_line && !ro_hold));
  a_r6_fall_position: assert property (@(posedge clk) disable iff (rst)
    $fell(exp_q) |-> ($past(pix_pos) == ($past(frame_mode) ? P_FF : P_FD)));
endmodule

// File: rtl/shutter_seq.sv
`timescale 1ns/1ps
module shutter_seq
  import shut_pkg::*;
#(
  parameter int PIX_W      = 12,
  parameter int SUB_ON     = 100,
  parameter int SUB_OFF    = 180,
  parameter int RISE_POS   = 1416,
  parameter int FALL_DRAFT = 1338,
  parameter int FALL_FRAME = 1260
)(
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_load,
  input  logic             cfg_en,
  input  logic [VCW-1:0]   cfg_vcnt,
  input  logic [HCW-1:0]   cfg_hcnt,
  input  logic [VCW-1:0]   cfg_fsel,
  input  logic             ro_hold,
  input  logic             frame_mode,
  input  logic             line_start,
  input  logic             field_start,
  input  logic [PIX_W-1:0] pix_pos,
  input  logic             ro_line,
  output logic             sub_req,
  output logic             exp_lvl,
  output logic             long_busy
);
  shut_cfg_t      cfg_in, act;
  logic [VCW-1:0] fcnt;
  logic [HCW-1:0] line_idx;

  assign cfg_in = '{en: cfg_en, vcnt: cfg_vcnt, hcnt: cfg_hcnt, fsel: cfg_fsel};

  shut_field_ctl u_ctl (
    .clk(clk), .rst(rst), .cfg_load(cfg_load), .cfg_in(cfg_in),
    .line_start(line_start), .field_start(field_start),
    .act(act), .fcnt(fcnt), .line_idx(line_idx), .busy(long_busy)
  );

  shut_pulse_gen #(
    .PIX_W(PIX_W), .SUB_ON(SUB_ON), .SUB_OFF(SUB_OFF), .RISE_POS(RISE_POS),
    .FALL_DRAFT(FALL_DRAFT), .FALL_FRAME(FALL_FRAME)
  ) u_gen (
    .clk(clk), .rst(rst), .act(act), .fcnt(fcnt), .line_idx(line_idx),
    .pix_pos(pix_pos), .ro_line(ro_line), .ro_hold(ro_hold),
    .frame_mode(frame_mode), .sub_q(sub_req), .exp_q(exp_lvl)
  );
endmodule

// File: tb/shutter_seq_bench.sv
`timescale 1ns/1ps
module shutter_seq_bench;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst, cfg_load, cfg_en, ro_hold, frame_mode;
  logic        line_start, field_start, ro_line;
  logic [9:0]  cfg_vcnt, cfg_fsel;
  logic [10:0] cfg_hcnt;
  logic [11:0] pix_pos;
  logic        sub_req, exp_lvl, long_busy;
  int          n_run = 0, n_fail = 0;
  bit          done = 0;

  shutter_seq u_shutter_seq (
    .clk(clk), .rst(rst), .cfg_load(cfg_load), .cfg_en(cfg_en),
    .cfg_vcnt(cfg_vcnt), .cfg_hcnt(cfg_hcnt), .cfg_fsel(cfg_fsel),
    .ro_hold(ro_hold), .frame_mode(frame_mode), .line_start(line_start),
    .field_start(field_start), .pix_pos(pix_pos), .ro_line(ro_line),
    .sub_req(sub_req), .exp_lvl(exp_lvl), .long_busy(long_busy)
  );

  // row: fs, ls, ro, pix[11:0], expected {sub, exp, busy}
  localparam logic [17:0] VEC [0:14] = '{
    {3'b000, 12'd99,   3'b000},
    {3'b000, 12'd100,  3'b100},
    {3'b000, 12'd179,  3'b100},
    {3'b000, 12'd180,  3'b000},
    {3'b010, 12'd0,    3'b000},
    {3'b000, 12'd100,  3'b100},
    {3'b000, 12'd180,  3'b010},
    {3'b010, 12'd0,    3'b010},
    {3'b000, 12'd100,  3'b010},
    {3'b010, 12'd0,    3'b010},
    {3'b001, 12'd1337, 3'b010},
    {3'b001, 12'd1338, 3'b000},
    {3'b001, 12'd1416, 3'b000},
    {3'b110, 12'd0,    3'b000},
    {3'b000, 12'd100,  3'b100}
  };

  task automatic step(input logic ls, input logic fs, input logic ro,
                      input logic [11:0] px, input logic ld);
    @(negedge clk);
    line_start = ls; field_start = fs; ro_line = ro; pix_pos = px; cfg_load = ld;
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [2:0] exp3);
    logic [2:0] got;
    got = {sub_req, exp_lvl, long_busy};
    n_run++;
    if (got !== exp3) begin
      n_fail++;
      $display("FAIL %s {sub,exp,busy} actual=%b expected=%b", tag, got, exp3);
    end
  endtask

  task automatic set_cfg(input logic en, input logic [9:0] v,
                         input logic [10:0] h, input logic [9:0] f);
    cfg_en = en; cfg_vcnt = v; cfg_hcnt = h; cfg_fsel = f;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; cfg_load = 0; line_start = 0; field_start = 0; ro_line = 0;
    pix_pos = '0; ro_hold = 0; frame_mode = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    chk("R10 reset state", 3'b000);
  endtask

  initial begin
    #(20000 * 5);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    set_cfg(0, 0, 0, 0);

    // table: high-speed shutter, V=0 H=1 F=0 (R3, R2)
    do_reset();
    set_cfg(1, 10'd0, 11'd1, 10'd0);
    step(0, 0, 0, 0, 1);
    step(1, 1, 0, 0, 0);
    for (int i = 0; i < 15; i++) begin
      step(VEC[i][16], VEC[i][17], VEC[i][15], VEC[i][14:3], 0);
      chk($sformatf("R3 vector %0d", i), VEC[i][2:0]);
    end

    // shutter disabled, readout positions, suppress (R1, R6, R7)
    do_reset();
    step(1, 1, 0, 0, 0);
    step(0, 0, 0, 100, 0);      chk("R1 no pulse when disabled", 3'b000);
    step(1, 0, 0, 0, 0);
    step(0, 0, 1, 1416, 0);     chk("R1 rise at 1416", 3'b010);
    step(1, 1, 0, 0, 0);
    step(1, 0, 0, 0, 0);
    step(0, 0, 1, 1338, 0);     chk("R6 draft fall at 1338", 3'b000);
    step(0, 0, 1, 1416, 0);     chk("R1 rise again", 3'b010);
    frame_mode = 1;
    step(1, 1, 0, 0, 0);
    step(0, 0, 1, 1338, 0);     chk("R6 1338 ignored in frame mode", 3'b010);
    step(0, 0, 1, 1260, 0);     chk("R6 frame fall at 1260", 3'b000);
    step(0, 0, 1, 1416, 0);     chk("R6 rise after frame fall", 3'b010);
    ro_hold = 1;
    step(1, 1, 0, 0, 0);
    step(0, 0, 1, 1260, 0);     chk("R7 readout suppressed", 3'b010);
    ro_hold = 0; frame_mode = 0;

    // long exposure V=2 H=0 F=1 (R4, R5, R8, R9, R2)
    do_reset();
    set_cfg(1, 10'd2, 11'd0, 10'd1);
    step(0, 0, 0, 0, 1);
    step(1, 1, 0, 0, 0);        chk("R8 busy in field 0", 3'b001);
    step(0, 0, 0, 100, 0);      chk("R5 no pulse in field 0", 3'b001);
    step(1, 1, 0, 0, 0);
    step(0, 0, 0, 100, 0);      chk("R5 pulse in field 1", 3'b101);
    step(0, 0, 0, 180, 0);      chk("R2 single pulse ends, exp rises", 3'b011);
    step(1, 0, 0, 0, 0);
    step(0, 0, 1, 1338, 0);     chk("R4 intermediate readout ignored", 3'b011);
    set_cfg(0, 10'd0, 11'd0, 10'd0);
    step(0, 0, 0, 0, 1);        // refused: busy
    step(1, 1, 0, 0, 0);        chk("R8 busy clear in final field", 3'b010);
    step(1, 0, 0, 0, 0);
    step(0, 0, 1, 1338, 0);     chk("R4 final readout ends exposure", 3'b000);
    step(0, 0, 1, 1416, 0);     chk("R4 no 1416 rise with burst", 3'b000);
    step(1, 1, 0, 0, 0);        chk("R9 refused load left V=2", 3'b001);
    step(1, 1, 0, 0, 0);
    step(0, 0, 0, 100, 0);      chk("R9 refused load left enable", 3'b101);
    step(1, 1, 0, 0, 0);        chk("R8 final field again", 3'b000);
    set_cfg(1, 10'd0, 11'd0, 10'd3);
    step(0, 0, 0, 0, 1);        // accepted
    step(1, 1, 0, 0, 0);
    step(0, 0, 0, 100, 0);      chk("R5 F beyond V gives no burst", 3'b000);
    step(1, 0, 0, 0, 0);
    step(0, 0, 1, 1338, 0);     chk("R6 fall stays low", 3'b000);
    step(0, 0, 1, 1416, 0);     chk("R5 rise at 1416 without burst", 3'b010);
    set_cfg(1, 10'd0, 11'd0, 10'd0);
    step(0, 0, 0, 0, 1);
    step(0, 0, 0, 100, 0);      chk("R9 load not applied mid-field", 3'b010);
    step(1, 1, 0, 0, 0);
    step(0, 0, 0, 100, 0);      chk("R9 load applied at cycle start", 3'b110);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    done = 1;
    $finish;
  end
endmodule